// File: doc/BRIEF.md
# Select-Line Window Shifter with Store Register

This block picks a narrow window out of a wider data word and keeps chosen windows in a small result register. A 7-bit input word and a bank of four select lines enter a combinational shifter. Each select line stands for one shift amount and picks a 4-bit slice of the word. That slice appears at once on a visible intermediate bus. A shared store enable decides which of those slices are kept in a 4-bit result. While store is low, the result keeps whatever it last captured.

The select lines are meant to be one-hot. The two illegal cases get defined digital behaviour here, not the floating or fighting nodes of a pass-gate network. With no line active, the bus reads zero. With several lines active, the bus is the bitwise OR of every selected slice, which behaves like a wired-OR. In both cases a combinational error flag is raised. The flag tracks the select lines directly and is never stored.

The result storage is a bank of enabled registers on the block clock. On every clock edge where store is high, the result takes the current bus value, so it follows the bus one cycle behind. When store falls, the last value taken is held. A synchronous reset clears the result and takes priority over store.

Top module: `shift_window_latch`

## Requirements
- R1: With exactly select line k high (k = 0..3, line k is bit k of `shiftSel`), `shiftBus[i]` equals `dataIn[i+k]` for i = 0..3 in the same cycle. Line 0 passes bits 3..0 and line 3 passes bits 6..3.
- R2: With all select lines low, `shiftBus` is 4'b0000.
- R3: With two or more select lines high, `shiftBus` is the bitwise OR of the windows that each active line selects alone.
- R4: `selError` is high exactly when the number of high select lines differs from one. It depends on nothing but `shiftSel`, and neither store nor reset changes it.
- R5: At a rising clock edge with `rst` low and `store` high, `result` takes the value `shiftBus` had just before that edge.
- R6: At a rising clock edge with `rst` low and `store` low, `result` keeps its value, whatever the data and select inputs do.
- R7: At a rising clock edge with `rst` high, `result` becomes 4'b0000, even if `store` is high.
- R8: `shiftBus` is combinational from `dataIn` and `shiftSel` alone. Neither `store` nor `rst` affects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the result |
| dataIn | input | 7 | Source word, bit 6 most significant |
| shiftSel | input | 4 | Select lines; line k picks the window starting at bit k |
| store | input | 1 | Shared enable for the result register |
| shiftBus | output | 4 | Combinational window before storage |
| result | output | 4 | Stored window |
| selError | output | 1 | High when the select lines are not one-hot |

## Verification
The hardest case to bring about is a store with a wrong select code, where a zero or OR-merged window has to land in the result. A later store-low stretch must then keep that value while the select lines and data keep changing. Random stimulus rarely creates such sequences when the select draw is weighted towards legal codes. So the bench also uses a uniform draw of all sixteen select codes, together with an independent random store. It adds directed sequences that store an all-low and an all-high select code and then churn the inputs with store low. Reset is also asserted together with store high, to show that clearing wins over capture.

// File: rtl/shift_window_pkg.sv
package shift_window_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;     // synchronous clear of the result
    logic capture;   // load the result from the bus
    logic selError;  // select lines are not one-hot
  } ctrlStrobes_t;

  // Count of high bits in a select vector
  function automatic int unsigned countHigh(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned b = 0; b < n; b++) c += v[b] ? 1 : 0;
    return c;
  endfunction

endpackage

// File: rtl/shift_window_ctrl.sv
module shift_window_ctrl
  import shift_window_pkg::*;
#(
  parameter int unsigned NSEL = 4
) (
  input  logic            rst,
  input  logic            store,
  input  logic [NSEL-1:0] shiftSel,
  output logic [NSEL-1:0] windowEn,
  output ctrlStrobes_t    strobes
);

  logic [31:0] selWide;
  int unsigned activeCnt;

  always_comb begin
    selWide = '0;
    selWide[NSEL-1:0] = shiftSel;
    activeCnt = countHigh(selWide, NSEL);
  end

  // Every active line enables its own window; illegal codes are flagged
  assign windowEn         = shiftSel;
  assign strobes.selError = (activeCnt != 1);
  assign strobes.clear    = rst;
  assign strobes.capture  = store & ~rst;

endmodule

// File: rtl/shift_window_dp.sv
module shift_window_dp
  import shift_window_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned OUT_W  = 4,
  parameter int unsigned NSEL   = DATA_W - OUT_W + 1
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [NSEL-1:0]   windowEn,
  input  ctrlStrobes_t      strobes,
  output logic [OUT_W-1:0]  shiftBus,
  output logic [OUT_W-1:0]  result
);

  logic [OUT_W-1:0] winVal [NSEL];

  // One gated window per select line
  for (genvar k = 0; k < NSEL; k++) begin : g_win
    assign winVal[k] = windowEn[k] ? dataIn[k+OUT_W-1:k] : '0;
  end

  // Wired-OR merge: zero when idle, OR of windows on contention
  always_comb begin
    shiftBus = '0;
    for (int k = 0; k < NSEL; k++) shiftBus |= winVal[k];
  end

  // Result storage, loaded while store is high
  always_ff @(posedge clk) begin
    if (strobes.clear)        result <= '0;
    else if (strobes.capture) result <= shiftBus;
  end

endmodule

// File: rtl/shift_window_latch.sv
module shift_window_latch
  import shift_window_pkg::*;
#(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned OUT_W  = 4,
  localparam int unsigned NSEL  = DATA_W - OUT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [NSEL-1:0]   shiftSel,
  input  logic              store,
  output logic [OUT_W-1:0]  shiftBus,
  output logic [OUT_W-1:0]  result,
  output logic              selError
);

  ctrlStrobes_t    strobes;
  logic [NSEL-1:0] windowEn;

  shift_window_ctrl #(.NSEL(NSEL)) u_ctrl (
    .rst      (rst),
    .store    (store),
    .shiftSel (shiftSel),
    .windowEn (windowEn),
    .strobes  (strobes)
  );

  shift_window_dp #(.DATA_W(DATA_W), .OUT_W(OUT_W), .NSEL(NSEL)) u_dp (
    .clk      (clk),
    .dataIn   (dataIn),
    .windowEn (windowEn),
    .strobes  (strobes),
    .shiftBus (shiftBus),
    .result   (result)
  );

  assign selError = strobes.selError;

endmodule

// File: rtl/shift_window_latch_chk.sv
module shift_window_latch_chk #(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned OUT_W  = 4,
  parameter int unsigned NSEL   = DATA_W - OUT_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dataIn,
  input logic [NSEL-1:0]   shiftSel,
  input logic              store,
  input logic [OUT_W-1:0]  shiftBus,
  input logic [OUT_W-1:0]  result,
  input logic              selError
);

  AST_LINE0_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (shiftSel == NSEL'(1)) |-> (shiftBus == dataIn[OUT_W-1:0])); // R1

  AST_TOP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (shiftSel == NSEL'(1) << (NSEL-1)) |-> (shiftBus == dataIn[DATA_W-1:DATA_W-OUT_W])); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (shiftSel == '0) |-> (shiftBus == '0)); // R2

  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !selError |-> ($countones(shiftSel) == 1)); // R4

  AST_ERR_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    ($countones(shiftSel) != 1) |-> selError); // R4

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    store |=> (result == $past(shiftBus))); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !store |=> $stable(result)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (result == '0)); // R7

endmodule

bind shift_window_latch shift_window_latch_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W), .NSEL(NSEL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dataIn   (dataIn),
  .shiftSel (shiftSel),
  .store    (store),
  .shiftBus (shiftBus),
  .result   (result),
  .selError (selError)
);

// File: tb/shift_window_latch_test.sv
module shift_window_latch_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] dataIn;
  logic [3:0] shiftSel;
  logic       store;
  logic [3:0] shiftBus;
  logic [3:0] result;
  logic       selError;

  int checks = 0;
  int errors = 0;
  logic [3:0] modelResult;

  always #5ns clk = ~clk;

  shift_window_latch uut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .shiftSel(shiftSel),
    .store(store), .shiftBus(shiftBus), .result(result), .selError(selError)
  );

  function automatic logic [3:0] expBus(input logic [6:0] d, input logic [3:0] s);
    logic [3:0] acc;
    acc = '0;
    for (int k = 0; k < 4; k++)
      if (s[k]) acc |= d[k +: 4];
    return acc;
  endfunction

  function automatic logic expErr(input logic [3:0] s);
    return !(s == 4'b0001 || s == 4'b0010 || s == 4'b0100 || s == 4'b1000);
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic string busTag(input logic [3:0] s);
    if (s == 4'b0000) return "R2";
    if (!expErr(s))   return "R1";
    return "R3";
  endfunction

  // Drive one cycle: check the result from the last edge, apply inputs, check the combinational outputs
  task automatic step(input logic r, input logic [6:0] d, input logic [3:0] s, input logic st);
    @(negedge clk);
    check(st ? "R5/R6/R7 result" : "R5/R6/R7 result", result, modelResult);
    rst = r; dataIn = d; shiftSel = s; store = st;
    #1ns;
    check(busTag(s), shiftBus, expBus(d, s));
    check("R4", {3'b0, selError}, {3'b0, expErr(s)});
    if (r) modelResult = '0;
    else if (st) modelResult = expBus(d, s);
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; dataIn = '0; shiftSel = '0; store = 1'b0;
    modelResult = '0;
    @(negedge clk); @(negedge clk);
    check("R7 reset state", result, 4'b0000);

    // R1: each legal select on a fixed word
    for (int k = 0; k < 4; k++) step(1'b0, 7'b1101001, 4'(1 << k), 1'b1);
    // R2: idle select stored, then held while inputs churn (R6)
    step(1'b0, 7'b1111111, 4'b0000, 1'b1);
    for (int j = 0; j < 4; j++) step(1'b0, 7'($urandom), 4'($urandom), 1'b0);
    // R3: all lines high stored, then held
    step(1'b0, 7'b1010110, 4'b1111, 1'b1);
    step(1'b0, 7'b0101001, 4'b0001, 1'b0);
    step(1'b0, 7'b0110011, 4'b0101, 1'b1);
    // R7: reset wins over store; R8: bus unaffected by reset
    step(1'b1, 7'b1111111, 4'b1000, 1'b1);
    step(1'b0, 7'b0000000, 4'b0010, 1'b0);
    // R4/R8: toggling store alone leaves bus and flag unchanged
    step(1'b0, 7'b1001011, 4'b0110, 1'b0);
    step(1'b0, 7'b1001011, 4'b0110, 1'b1);

    // Random: weighted towards legal codes, then uniform codes
    for (int n = 0; n < 400; n++) begin
      logic [3:0] s;
      if (n < 200 && ($urandom % 10) < 7) s = 4'(1 << ($urandom % 4));
      else s = 4'($urandom);
      step(($urandom % 25) == 0, 7'($urandom), s, 1'($urandom));
    end
    step(1'b0, 7'b0, 4'b0001, 1'b0);
    @(negedge clk);
    check("R6 final hold", result, modelResult);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule